// File: doc/BRIEF.md
# Key Matrix Scanner with Completion Interrupt

This block reads a 5 x 6 key matrix when the command decoder asks for it. It drives one key-source line at a time and waits a fixed settle period. It then samples the six return lines, which are pulled low and read high under a pressed key. All sources are released for a short gap before the next line is driven. After the fifth source has been sampled, the whole 30-bit key map is published in one cycle and a completion interrupt is raised toward the host.

The host reads the map through a separate shifter. It acknowledges by raising its load strobe, and the rising edge of that strobe clears the interrupt. The matrix is never scanned without a request, so the published map only changes when a scan completes. The return lines and the load strobe come from pins and pass through two-flop synchronizers before they are used.

Top module: `kmx_scanner`

## Requirements
- R1: After reset all source lines are released (0), the key map is all zeros and the interrupt is low.
- R2: A scan drives each source line on its own, never two at once. It goes from source 0 up to source 4 and drives exactly five steps per request.
- R3: Each source line stays driven (1) for exactly SETTLE_CYC (default 16) consecutive cycles. The returns are sampled in the last of those cycles.
- R4: Between two consecutive steps of a scan, all source lines are released for exactly GAP_CYC (default 4) cycles.
- R5: Key map bit 6*s + r is 1 exactly when return r was high while source s was driven. Bit 0 (source 0, return 0) is the LSB and bit 29 (source 4, return 5) is the MSB.
- R6: When the last step's sample is taken, the new key map and a high interrupt both appear in the same cycle.
- R7: The interrupt clears on a rising edge of the load strobe, three clock edges after the strobe is first seen high. Holding the strobe high, or lowering it, has no further effect.
- R8: The key map holds its value at all times except at scan completion, including during a scan whose keys differ.
- R9: Without a scan request, no source line is ever driven and the key map does not change.
- R10: A scan request that arrives while a scan is running is ignored. The running scan is neither restarted nor extended, and no second scan follows it.
- R11: A load edge during a scan clears a pending interrupt and does not disturb the scan or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_req_i | input | 1 | One-cycle scan request from the command decoder |
| load_i | input | 1 | Host load strobe (asynchronous pin); its rising edge acknowledges |
| ret_i | input | NUM_RET (6) | Key return lines, high when a key on the driven source is pressed |
| src_o | output | NUM_SRC (5) | Key source drives, active high, at most one at a time |
| key_map_o | output | NUM_SRC*NUM_RET (30) | Published key map, one bit per key |
| irq_o | output | 1 | Scan-complete interrupt |

## Verification
The hardest case to reach from the ports is a host acknowledge that lands in the middle of a scan while an earlier interrupt is still pending. In that case the interrupt must drop, the scan must continue, and the interrupt must come back with the new map. The bench leaves one interrupt uncleared, starts a new scan, and raises load partway through that scan. A matrix model in the bench turns the driven source and a pressed-key vector into return levels, so every scan has a known map to compare against. A cycle monitor measures the drive and gap lengths and the order of the sources. A second request issued mid-scan then shows that scans are neither restarted nor repeated.

// File: rtl/kmx_pkg.sv
// Package: kmx_pkg
// Shared types for the key matrix scanner. The sequencer walks through
// three states: idle, driving one source, and a release gap.
package kmx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_GAP   = 2'd2
    } scan_st_e;

endpackage

// File: rtl/kmx_sync.sv
// Module: kmx_sync
// Two-flop synchronizer for a bundle of independent pin inputs.
// Assumes each bit is meaningful on its own; bits in the bundle are not
// kept coherent with one another.
module kmx_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two register stages bring the pins into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/kmx_seq.sv
// Module: kmx_seq
// Scan sequencer. On a request seen while idle, it drives sources 0 to
// NUM_SRC-1 in turn. Each source is held for SETTLE_CYC cycles, with
// GAP_CYC release cycles between steps. It pulses sample_stb in the last
// drive cycle of each step, and done_stb along with the final sample.
// Assumes SETTLE_CYC >= 3, which covers the two-cycle return synchronizer,
// and GAP_CYC >= 1.
module kmx_seq
    import kmx_pkg::*;
#(
    parameter int NUM_SRC    = 5,
    parameter int SETTLE_CYC = 16,
    parameter int GAP_CYC    = 4,
    parameter int IDX_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_req_i,
    output logic               sample_stb_o,
    output logic               done_stb_o,
    output logic [IDX_W-1:0]   src_idx_o,
    output logic [NUM_SRC-1:0] src_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + GAP_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(NUM_SRC - 1);

    scan_st_e         state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    // State, step counter and source index advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (scan_req_i) begin
                        state_q <= ST_DRIVE;
                        cnt_q   <= '0;
                        idx_q   <= '0;
                    end
                end
                ST_DRIVE: begin
                    if (cnt_q == SETTLE_LAST) begin
                        cnt_q   <= '0;
                        state_q <= (idx_q == LAST_IDX) ? ST_IDLE : ST_GAP;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (cnt_q == GAP_LAST) begin
                        cnt_q   <= '0;
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= ST_DRIVE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes for the capture stage.
    always_comb begin
        sample_stb_o = (state_q == ST_DRIVE) && (cnt_q == SETTLE_LAST);
        done_stb_o   = sample_stb_o && (idx_q == LAST_IDX);
    end

    assign src_idx_o = idx_q;

    // One decoded drive line per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_o[g] = (state_q == ST_DRIVE) && (idx_q == IDX_W'(g));
    end

    p_src_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_o))
        else $error("two sources driven at once");

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && cnt_q == GAP_LAST)
        |=> (idx_q == $past(idx_q) + IDX_W'(1)))
        else $error("source index did not advance by one");

    p_drive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && cnt_q != '0) |-> $stable(src_o))
        else $error("source changed inside its settle window");

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !scan_req_i) |=> (src_o == '0))
        else $error("source driven without a request");

endmodule

// File: rtl/kmx_capture.sv
// Module: kmx_capture
// Collects each step's return sample into a shadow vector. The published
// key map is loaded from that vector, including the last slice, only at
// scan completion. Assumes the returns are already synchronized.
module kmx_capture #(
    parameter int NUM_SRC = 5,
    parameter int NUM_RET = 6,
    parameter int IDX_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_stb_i,
    input  logic                       done_stb_i,
    input  logic [IDX_W-1:0]           src_idx_i,
    input  logic [NUM_RET-1:0]         ret_i,
    output logic [NUM_SRC*NUM_RET-1:0] key_map_o
);
    localparam int NKEY = NUM_SRC * NUM_RET;

    logic [NKEY-1:0] shadow_q;
    logic [NKEY-1:0] shadow_nxt;
    logic [NKEY-1:0] map_q;

    // Per-source slice: take the fresh sample for the step being driven.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slice
        assign shadow_nxt[g*NUM_RET +: NUM_RET] =
            (sample_stb_i && src_idx_i == IDX_W'(g)) ? ret_i
                                                     : shadow_q[g*NUM_RET +: NUM_RET];
    end

    // Shadow accumulation and publication of the completed map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            map_q    <= '0;
        end else begin
            shadow_q <= shadow_nxt;
            if (done_stb_i) begin
                map_q <= shadow_nxt;
            end
        end
    end

    assign key_map_o = map_q;

    p_map_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_stb_i |=> $stable(key_map_o))
        else $error("key map moved outside completion");

    p_last_slice_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb_i |=> (key_map_o[NKEY-1 -: NUM_RET] == $past(ret_i)))
        else $error("top slice does not match final sample");

endmodule

// File: rtl/kmx_irq.sv
// Module: kmx_irq
// Completion interrupt. It is set by the done strobe and cleared by a rising
// edge of the synchronized load strobe. A set in the same cycle as a clear
// wins, so a finished scan is never lost.
module kmx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic load_sync_i,
    input  logic done_stb_i,
    output logic irq_o
);
    logic load_prev_q;
    logic load_rise;
    logic irq_q;

    assign load_rise = load_sync_i && !load_prev_q;

    // Edge history of the load strobe and the interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_prev_q <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            load_prev_q <= load_sync_i;
            if (done_stb_i) begin
                irq_q <= 1'b1;
            end else if (load_rise) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign irq_o = irq_q;

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb_i |=> irq_o)
        else $error("interrupt not raised at completion");

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rise && !done_stb_i) |=> !irq_o)
        else $error("interrupt not cleared by load edge");

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_rise && !done_stb_i) |=> $stable(irq_o))
        else $error("interrupt changed without cause");

endmodule

// File: rtl/kmx_scanner.sv
// Module: kmx_scanner
// Top level of the key matrix scanner. It synchronizes the pin inputs,
// sequences the source drives, captures the returns and raises the
// completion interrupt. Assumes scan_req_i is a synchronous one-cycle pulse
// and SETTLE_CYC >= 3.
module kmx_scanner #(
    parameter int NUM_SRC    = 5,
    parameter int NUM_RET    = 6,
    parameter int SETTLE_CYC = 16,
    parameter int GAP_CYC    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scan_req_i,
    input  logic                       load_i,
    input  logic [NUM_RET-1:0]         ret_i,
    output logic [NUM_SRC-1:0]         src_o,
    output logic [NUM_SRC*NUM_RET-1:0] key_map_o,
    output logic                       irq_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_RET-1:0] ret_sync;
    logic               load_sync;
    logic               sample_stb;
    logic               done_stb;
    logic [IDX_W-1:0]   src_idx;

    kmx_sync #(.WIDTH(NUM_RET)) u_ret_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ret_i),
        .q_o   (ret_sync)
    );

    kmx_sync #(.WIDTH(1)) u_load_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (load_i),
        .q_o   (load_sync)
    );

    kmx_seq #(
        .NUM_SRC    (NUM_SRC),
        .SETTLE_CYC (SETTLE_CYC),
        .GAP_CYC    (GAP_CYC),
        .IDX_W      (IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_req_i   (scan_req_i),
        .sample_stb_o (sample_stb),
        .done_stb_o   (done_stb),
        .src_idx_o    (src_idx),
        .src_o        (src_o)
    );

    kmx_capture #(
        .NUM_SRC (NUM_SRC),
        .NUM_RET (NUM_RET),
        .IDX_W   (IDX_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_stb_i (sample_stb),
        .done_stb_i   (done_stb),
        .src_idx_i    (src_idx),
        .ret_i        (ret_sync),
        .key_map_o    (key_map_o)
    );

    kmx_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_sync_i (load_sync),
        .done_stb_i  (done_stb),
        .irq_o       (irq_o)
    );

endmodule

// File: tb/kmx_scanner_bench.sv
// Bench: kmx_scanner_bench
// Directed scenarios against a behavioural key matrix. A negedge monitor
// measures the drive runs, the gaps and the source order.
module kmx_scanner_bench;
    localparam int NS     = 5;
    localparam int NR     = 6;
    localparam int NK     = NS * NR;
    localparam int SETTLE = 16;
    localparam int GAP    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_req = 1'b0;
    logic          load = 1'b0;
    logic [NR-1:0] ret;
    logic [NS-1:0] src;
    logic [NK-1:0] key_map;
    logic          irq;
    logic [NK-1:0] pressed = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    kmx_scanner #(.NUM_SRC(NS), .NUM_RET(NR), .SETTLE_CYC(SETTLE), .GAP_CYC(GAP))
    u_kmx_scanner (
        .clk(clk), .rst_n(rst_n), .scan_req_i(scan_req), .load_i(load),
        .ret_i(ret), .src_o(src), .key_map_o(key_map), .irq_o(irq)
    );

    // Matrix model: a pressed key ties its return to its driven source.
    always_comb begin
        ret = '0;
        for (int s = 0; s < NS; s++)
            for (int r = 0; r < NR; r++)
                if (src[s] && pressed[s*NR+r]) ret[r] = 1'b1;
    end

    // Drive/gap/order monitor, sampled on the falling edge.
    int mon_steps = 0, mon_order_err = 0, mon_len_err = 0;
    int mon_gap_err = 0, mon_multi_err = 0;
    int run_len = 0, zero_len = 0;
    logic [NS-1:0] prev_src = '0;
    always @(negedge clk) begin
        if ($countones(src) > 1) mon_multi_err++;
        if (src != prev_src) begin
            if (prev_src != '0 && run_len != SETTLE) mon_len_err++;
            if (src != '0) begin
                if (prev_src != '0) mon_gap_err++;
                else if ((mon_steps % NS) != 0 && zero_len != GAP) mon_gap_err++;
                for (int s = 0; s < NS; s++)
                    if (src[s] && s != (mon_steps % NS)) mon_order_err++;
                mon_steps++;
                run_len = 1;
            end else begin
                zero_len = 1;
            end
        end else if (src != '0) run_len++;
        else zero_len++;
        prev_src = src;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk); scan_req = 1'b1;
        @(negedge clk); scan_req = 1'b0;
    endtask

    task automatic load_pulse();
        @(negedge clk); load = 1'b1;
        repeat (4) @(negedge clk);
        load = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_irq(input logic [NK-1:0] old, output bit got, output bit early);
        got = 1'b0; early = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq) begin got = 1'b1; break; end
            if (key_map !== old) early = 1'b1;
        end
    endtask

    // R2 R3 R4 R5 R6 R8: one full scan of a given pattern.
    task automatic t_scan(input logic [NK-1:0] pat, input string name);
        bit got, early;
        logic [NK-1:0] old;
        int s0, o0, l0, g0, m0;
        pressed = pat; old = key_map;
        s0 = mon_steps; o0 = mon_order_err; l0 = mon_len_err;
        g0 = mon_gap_err; m0 = mon_multi_err;
        pulse_req();
        wait_irq(old, got, early);
        chk(got, "R6", {name, " irq raised"}, 64'(got), 1);
        chk(key_map === pat, "R5", {name, " key map"}, 64'(key_map), 64'(pat));
        chk(!early, "R8", {name, " map held until completion"}, 64'(early), 0);
        @(negedge clk);
        chk(mon_steps - s0 == NS, "R2", {name, " step count"}, 64'(mon_steps - s0), NS);
        chk(mon_order_err == o0 && mon_multi_err == m0, "R2", {name, " order/one-hot"},
            64'(mon_order_err - o0 + mon_multi_err - m0), 0);
        chk(mon_len_err == l0, "R3", {name, " settle length"}, 64'(mon_len_err - l0), 0);
        chk(mon_gap_err == g0, "R4", {name, " gap length"}, 64'(mon_gap_err - g0), 0);
    endtask

    // R7: exact clear timing on the load edge; holding or lowering has no effect.
    task automatic t_load_clear();
        @(negedge clk); load = 1'b1;
        repeat (2) @(negedge clk);
        chk(irq === 1'b1, "R7", "irq before third edge", 64'(irq), 1);
        @(negedge clk);
        chk(irq === 1'b0, "R7", "irq after third edge", 64'(irq), 0);
        repeat (20) @(negedge clk);
        chk(irq === 1'b0, "R7", "irq while load held", 64'(irq), 0);
        load = 1'b0;
        repeat (6) @(negedge clk);
        chk(irq === 1'b0, "R7", "irq after load falls", 64'(irq), 0);
    endtask

    // R9: with no request, keys change but nothing is driven and the map holds.
    task automatic t_no_request();
        logic [NK-1:0] old;
        int s0;
        old = key_map; s0 = mon_steps;
        pressed = 30'h1234_5678;
        repeat (200) @(negedge clk);
        chk(mon_steps == s0, "R9", "no source driven", 64'(mon_steps - s0), 0);
        chk(key_map === old, "R9", "map unchanged", 64'(key_map), 64'(old));
        chk(irq === 1'b0, "R9", "no interrupt", 64'(irq), 0);
    endtask

    // R10: a second request mid-scan neither restarts nor repeats the scan.
    task automatic t_req_during();
        bit got, early;
        int s0, o0;
        pressed = 30'h0F0F_0F0F;
        s0 = mon_steps; o0 = mon_order_err;
        pulse_req();
        repeat (40) @(negedge clk);
        pulse_req();
        wait_irq(key_map, got, early);
        chk(got && key_map === 30'h0F0F_0F0F, "R10", "map after extra request",
            64'(key_map), 64'(30'h0F0F_0F0F));
        repeat (150) @(negedge clk);
        chk(mon_steps - s0 == NS, "R10", "only one scan ran", 64'(mon_steps - s0), NS);
        chk(mon_order_err == o0, "R10", "no restart", 64'(mon_order_err - o0), 0);
    endtask

    // R11: load edge mid-scan clears a pending irq; the scan still completes correctly.
    task automatic t_load_during();
        bit got, early;
        logic [NK-1:0] old;
        chk(irq === 1'b1, "R11", "irq pending at start", 64'(irq), 1);
        old = key_map;
        pressed = 30'h2155_0AA3;
        pulse_req();
        repeat (30) @(negedge clk);
        load = 1'b1;
        repeat (4) @(negedge clk);
        chk(irq === 1'b0, "R11", "pending irq cleared mid-scan", 64'(irq), 0);
        load = 1'b0;
        wait_irq(old, got, early);
        chk(got, "R11", "irq after disturbed scan", 64'(got), 1);
        chk(key_map === 30'h2155_0AA3, "R11", "map after disturbed scan",
            64'(key_map), 64'(30'h2155_0AA3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(src === '0, "R1", "sources released", 64'(src), 0);
        chk(key_map === '0, "R1", "map cleared", 64'(key_map), 0);
        chk(irq === 1'b0, "R1", "irq low", 64'(irq), 0);

        t_scan(30'h0000_0000, "none");
        t_load_clear();
        t_scan(30'h3FFF_FFFF, "all");
        load_pulse();
        t_scan(30'h0000_0001, "key0");
        load_pulse();
        t_scan(30'h2000_0000, "key29");
        load_pulse();
        t_scan(30'h2AAA_AAAA, "checker");
        load_pulse();
        t_scan(30'h0084_2108 | 30'h0000_0041, "diag");
        load_pulse();
        t_no_request();
        t_req_during();
        t_load_during();
        load_pulse();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule